// File: doc/BRIEF.md
# Programmable-Threshold FIFO Controller

A single-clock first-in/first-out buffer, 256 words deep and 36 bits wide. It contains the storage array, the read and write pointers, an occupancy counter, and five level indicators: full, half-full, empty, almost-full and almost-empty. The almost-full and almost-empty thresholds are held in small offset registers. They are written through the same address-decoded port used for data access, either one at a time or all together from one packed word.

A host drives `en_i`, `req_i`, a direction bit and a 3-bit select. The select chooses the data queue or one of the configuration targets. A synchronous rewind input moves the read pointer back to the first location, so the block written so far can be read again. An optional request/acknowledge handshake predicts the boundaries. The acknowledge stays high while the buffer is far from its limits. Inside the almost regions it is rationed to one cycle in three, and it is withheld when the requested access would be refused.

The controller serves one of two queues in a bidirectional pair. The parameter `SIDE` picks which pair of offset registers in the shared address map belongs to this instance. With `SIDE` = 0, the A pair at selects 011 and 010 is used.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset the occupancy is zero and both pointers are at location 0. `empty_o` = 1, `aempty_o` = 1, `full_o` = `half_o` = `afull_o` = 0 and `ack_o` = 0. Both offsets hold 8.
- R2: With `sel_i` = 3'b111 and `en_i` = `req_i` = 1 at a rising edge, `rd_i` = 0 stores `wdata_i` and `rd_i` = 1 removes the oldest word. The removed word appears on `rdata_o` right after that edge, in write order.
- R3: At 256 stored words `full_o` = 1, and a further write changes neither the contents nor the count.
- R4: On an empty buffer a read is refused: `empty_o` stays 1 and `rdata_o` keeps its previous value.
- R5: `half_o` = 1 exactly when the occupancy is greater than 128.
- R6: `aempty_o` = 1 when occupancy ≤ almost-empty offset. `afull_o` = 1 when occupancy ≥ 256 − almost-full offset.
- R7: A write with select 3'b011 loads the almost-empty offset and 3'b010 loads the almost-full offset (for `SIDE` = 0; 3'b001 and 3'b000 for `SIDE` = 1). The value comes from bits 7:0 and the other bits are ignored.
- R8: A write with select 3'b101 loads both offsets from one word. The fields are: A almost-empty in bits 7:0, A almost-full in bits 16:9, B almost-empty in bits 25:18, B almost-full in bits 34:27. Bits 8, 17, 26 and 35 are ignored.
- R9: The following have no effect on data or thresholds: writes to selects 3'b110 and 3'b100, writes to the other side's offset selects, and any access with `en_i` = 0.
- R10: `rewind_ni` low at an edge returns the read pointer to location 0 and leaves the write pointer unchanged. The occupancy becomes the write pointer value, except that a full buffer stays full.
- R11: With `req_i` = 1 outside the relevant almost region, `ack_o` is high every cycle, whatever `en_i` is. With `req_i` = 0, `ack_o` is low the next cycle.
- R12: Inside the almost-full region (write requests) or the almost-empty region (read requests), `ack_o` is high at most one cycle in three. When the request is held continuously from an idle state, the pattern is 1,0,0,1,0,0.
- R13: `ack_o` stays low for a write request while full and for a read request while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Access enable, sampled at the rising edge |
| req_i | input | 1 | Request, needed together with en_i for any access |
| rd_i | input | 1 | Direction: 1 read, 0 write |
| sel_i | input | 3 | Target select (queue, offsets, packed offsets) |
| wdata_i | input | 36 | Write data or configuration word |
| rewind_ni | input | 1 | Synchronous retransmit strobe, active low |
| rdata_o | output | 36 | Last word read from the queue |
| ack_o | output | 1 | Handshake acknowledge |
| full_o | output | 1 | 256 words stored |
| half_o | output | 1 | More than 128 words stored |
| empty_o | output | 1 | No words stored |
| afull_o | output | 1 | Within the almost-full offset of full |
| aempty_o | output | 1 | Within the almost-empty offset of empty |

## Verification
A corrupted occupancy counter shows on the flag outputs in the cycle after the faulty edge, because all five flags are decoded from it without further delay. A wrong pointer stays hidden until a read. It then returns a word out of write order, which shows up at the first read after a rewind or after the buffer has wrapped. A corrupted offset register moves the almost-flag transition by one or more words. The same fault also moves the point where `ack_o` switches from continuous to one-in-three pacing, so both show together in the first walk through the thresholds.

// File: rtl/pff_pkg.sv
package pff_pkg;
  typedef enum logic [2:0] {
    SEL_OFS_AF_B = 3'b000,
    SEL_OFS_AE_B = 3'b001,
    SEL_OFS_AF_A = 3'b010,
    SEL_OFS_AE_A = 3'b011,
    SEL_CTRL     = 3'b100,
    SEL_OFS_ALL  = 3'b101,
    SEL_MBOX     = 3'b110,
    SEL_FIFO     = 3'b111
  } reg_sel_e;

  // packed-offset field k starts at bit k*PACK_STRIDE
  localparam int unsigned PACK_STRIDE = 9;
  localparam int unsigned PACK_AE_A   = 0;
  localparam int unsigned PACK_AE_B   = 2;
endpackage

// File: rtl/pff_ram.sv
module pff_ram #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pff_ptr_ctrl.sv
module pff_ptr_ctrl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic          rewind_i,
  output logic          wr_fire_o,
  output logic          rd_fire_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o
);
  logic is_full, is_empty;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign is_full   = (count_o == CW'(DEPTH));
  assign is_empty  = (count_o == '0);
  assign wr_fire_o = wr_req_i && !is_full && !rewind_i;
  assign rd_fire_o = rd_req_i && !is_empty && !rewind_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
      count_o  <= '0;
    end else if (rewind_i) begin
      rd_ptr_o <= '0;
      // block to re-read spans location 0 up to the write pointer
      count_o  <= is_full ? CW'(DEPTH) : CW'(wr_ptr_o);
    end else begin
      if (wr_fire_o) wr_ptr_o <= ptr_inc(wr_ptr_o);
      if (rd_fire_o) rd_ptr_o <= ptr_inc(rd_ptr_o);
      case ({wr_fire_o, rd_fire_o})
        2'b10:   count_o <= count_o + CW'(1);
        2'b01:   count_o <= count_o - CW'(1);
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/pff_ofs_regs.sv
module pff_ofs_regs
  import pff_pkg::*;
#(
  parameter int unsigned WIDTH     = 36,
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned OFS_RESET = 8,
  parameter int unsigned SIDE      = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [OFS_W-1:0] ae_ofs_o,
  output logic [OFS_W-1:0] af_ofs_o
);
  localparam logic [2:0] SEL_AE = (SIDE == 0) ? 3'(SEL_OFS_AE_A) : 3'(SEL_OFS_AE_B);
  localparam logic [2:0] SEL_AF = (SIDE == 0) ? 3'(SEL_OFS_AF_A) : 3'(SEL_OFS_AF_B);
  localparam int unsigned AE_LSB = ((SIDE == 0) ? PACK_AE_A : PACK_AE_B) * PACK_STRIDE;
  localparam int unsigned AF_LSB = AE_LSB + PACK_STRIDE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_ofs_o <= OFS_W'(OFS_RESET);
      af_ofs_o <= OFS_W'(OFS_RESET);
    end else if (wr_en_i) begin
      if (sel_i == SEL_AE) ae_ofs_o <= wdata_i[OFS_W-1:0];
      else if (sel_i == SEL_AF) af_ofs_o <= wdata_i[OFS_W-1:0];
      else if (sel_i == 3'(SEL_OFS_ALL)) begin
        ae_ofs_o <= wdata_i[AE_LSB +: OFS_W];
        af_ofs_o <= wdata_i[AF_LSB +: OFS_W];
      end
    end
  end
endmodule

// File: rtl/pff_flag_gen.sv
module pff_flag_gen #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned OFS_W = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0]    count_i,
  input  logic [OFS_W-1:0] ae_ofs_i,
  input  logic [OFS_W-1:0] af_ofs_i,
  output logic             full_o,
  output logic             half_o,
  output logic             empty_o,
  output logic             afull_o,
  output logic             aempty_o
);
  logic [CW-1:0] af_thr;

  assign af_thr   = CW'(DEPTH) - CW'(af_ofs_i);
  assign full_o   = (count_i == CW'(DEPTH));
  assign empty_o  = (count_i == '0);
  assign half_o   = (count_i > CW'(DEPTH / 2));
  assign afull_o  = (count_i >= af_thr);
  assign aempty_o = (count_i <= CW'(ae_ofs_i));
endmodule

// File: rtl/pff_ack_gen.sv
module pff_ack_gen #(
  parameter int unsigned ACK_GAP = 3,
  localparam int unsigned GW = (ACK_GAP > 2) ? $clog2(ACK_GAP) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rd_i,
  input  logic full_i,
  input  logic empty_i,
  input  logic afull_i,
  input  logic aempty_i,
  output logic ack_o
);
  logic          blocked, in_region, ack_d;
  logic [GW-1:0] gap_q;

  assign blocked   = rd_i ? empty_i : full_i;
  assign in_region = rd_i ? aempty_i : afull_i;
  assign ack_d     = req_i && !blocked && (!in_region || gap_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o <= 1'b0;
      gap_q <= '0;
    end else begin
      ack_o <= ack_d;
      if (ack_d)              gap_q <= GW'(ACK_GAP - 1);
      else if (gap_q != '0)   gap_q <= gap_q - GW'(1);
    end
  end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import pff_pkg::*;
#(
  parameter int unsigned WIDTH     = 36,
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned OFS_RESET = 8,
  parameter int unsigned SIDE      = 0,
  parameter int unsigned ACK_GAP   = 3,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             req_i,
  input  logic             rd_i,
  input  logic [2:0]       sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rewind_ni,
  output logic [WIDTH-1:0] rdata_o,
  output logic             ack_o,
  output logic             full_o,
  output logic             half_o,
  output logic             empty_o,
  output logic             afull_o,
  output logic             aempty_o
);
  logic             access, fifo_sel;
  logic             wr_fire, rd_fire;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic [OFS_W-1:0] ae_ofs, af_ofs;

  assign access   = en_i && req_i;
  assign fifo_sel = (sel_i == 3'(SEL_FIFO));

  pff_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni,
    .wr_req_i  (access && fifo_sel && !rd_i),
    .rd_req_i  (access && fifo_sel && rd_i),
    .rewind_i  (!rewind_ni),
    .wr_fire_o (wr_fire),
    .rd_fire_o (rd_fire),
    .wr_ptr_o  (wr_ptr),
    .rd_ptr_o  (rd_ptr),
    .count_o   (count)
  );

  pff_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk_i,
    .we_i    (wr_fire),
    .waddr_i (wr_ptr),
    .wdata_i (wdata_i),
    .re_i    (rd_fire),
    .raddr_i (rd_ptr),
    .rdata_o (rdata_o)
  );

  pff_ofs_regs #(
    .WIDTH(WIDTH), .OFS_W(OFS_W), .OFS_RESET(OFS_RESET), .SIDE(SIDE)
  ) u_ofs (
    .clk_i, .rst_ni,
    .wr_en_i  (access && !rd_i),
    .sel_i    (sel_i),
    .wdata_i  (wdata_i),
    .ae_ofs_o (ae_ofs),
    .af_ofs_o (af_ofs)
  );

  pff_flag_gen #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_flags (
    .count_i  (count),
    .ae_ofs_i (ae_ofs),
    .af_ofs_i (af_ofs),
    .full_o, .half_o, .empty_o, .afull_o, .aempty_o
  );

  pff_ack_gen #(.ACK_GAP(ACK_GAP)) u_ack (
    .clk_i, .rst_ni,
    .req_i    (req_i),
    .rd_i     (rd_i),
    .full_i   (full_o),
    .empty_i  (empty_o),
    .afull_i  (afull_o),
    .aempty_i (aempty_o),
    .ack_o    (ack_o)
  );
endmodule

// File: rtl/prog_flag_fifo_chk.sv
module prog_flag_fifo_chk #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8,
  parameter int unsigned CW    = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             req_i,
  input logic             rd_i,
  input logic [2:0]       sel_i,
  input logic             rewind_ni,
  input logic [WIDTH-1:0] rdata_o,
  input logic             ack_o,
  input logic             full_o,
  input logic             half_o,
  input logic             empty_o,
  input logic             afull_o,
  input logic [AW-1:0]    wr_ptr,
  input logic [AW-1:0]    rd_ptr,
  input logic [CW-1:0]    count
);
  logic fifo_acc;
  assign fifo_acc = en_i && req_i && (sel_i == 3'b111) && rewind_ni;

  p_full_not_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_acc && !rd_i && full_o) |=> (full_o && $stable(wr_ptr)));

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_acc && rd_i && empty_o) |=> (empty_o && $stable(rd_ptr) && $stable(rdata_o)));

  p_half_implies_nonempty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |-> !empty_o);

  p_rewind_ptrs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rewind_ni |=> (rd_ptr == '0 && $stable(wr_ptr)));

  p_ack_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);

  p_ack_spacing_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_i && !rd_i && afull_o) |=> !ack_o);

  p_ack_blocked_wr_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !rd_i && full_o) |=> !ack_o);

  p_ack_blocked_rd_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rd_i && empty_o) |=> !ack_o);
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .CW(CW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .req_i(req_i), .rd_i(rd_i),
  .sel_i(sel_i), .rewind_ni(rewind_ni), .rdata_o(rdata_o), .ack_o(ack_o),
  .full_o(full_o), .half_o(half_o), .empty_o(empty_o), .afull_o(afull_o),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
);

// File: tb/prog_flag_fifo_tb_top.sv
module prog_flag_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, req = 1'b0, rd = 1'b0, rewind_n = 1'b1;
  logic [2:0]  sel = 3'b111;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        ack, full, half, empty, afull, aempty;

  always #2 clk = ~clk;

  prog_flag_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .req_i(req), .rd_i(rd),
    .sel_i(sel), .wdata_i(wdata), .rewind_ni(rewind_n), .rdata_o(rdata),
    .ack_o(ack), .full_o(full), .half_o(half), .empty_o(empty),
    .afull_o(afull), .aempty_o(aempty)
  );

  int total = 0, bad = 0;
  int count_m, wp_m, rp_m, ae_m, af_m;
  logic [35:0] mem_m [256];
  logic [35:0] last_rd = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    en = 0; req = 0; rd = 0; sel = 3'b111; wdata = '0; rewind_n = 1;
  endtask

  task automatic check_flags(input string rq);
    chk(full == (count_m == 256), rq, "full", full, count_m == 256);
    chk(empty == (count_m == 0), rq, "empty", empty, count_m == 0);
    chk(half == (count_m > 128), rq, "half", half, count_m > 128);
    chk(aempty == (count_m <= ae_m), rq, "aempty", aempty, count_m <= ae_m);
    chk(afull == (count_m >= 256 - af_m), rq, "afull", afull, count_m >= 256 - af_m);
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 0;
    repeat (2) tick();
    rst_n = 1;
    tick();
    count_m = 0; wp_m = 0; rp_m = 0; ae_m = 8; af_m = 8;
  endtask

  task automatic push(input logic [35:0] d);
    en = 1; req = 1; rd = 0; sel = 3'b111; wdata = d;
    tick();
    if (count_m < 256) begin
      mem_m[wp_m] = d; wp_m = (wp_m + 1) % 256; count_m++;
    end
    idle_in();
  endtask

  task automatic pop(input string rq);
    logic [35:0] exp;
    en = 1; req = 1; rd = 1; sel = 3'b111;
    tick();
    if (count_m > 0) begin
      exp = mem_m[rp_m]; rp_m = (rp_m + 1) % 256; count_m--;
    end else exp = last_rd;
    chk(rdata == exp, rq, "rdata", rdata, exp);
    last_rd = rdata;
    idle_in();
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [35:0] d, input logic e);
    en = e; req = 1; rd = 0; sel = s; wdata = d;
    tick();
    idle_in();
  endtask

  task automatic do_rewind();
    rewind_n = 0;
    tick();
    rewind_n = 1;
    rp_m = 0;
    if (count_m != 256) count_m = wp_m;
  endtask

  task automatic t_reset();
    do_reset();
    check_flags("R1");
    chk(ack == 0, "R1", "ack", ack, 0);
  endtask

  task automatic t_basic();
    do_reset();
    push(36'h1_2345_6789); push(36'hF_0000_000F); push(36'h0_ABCD_EF01);
    check_flags("R2");
    for (int i = 0; i < 3; i++) pop("R2");
    check_flags("R2");
    // en low with request: nothing stored
    en = 0; req = 1; rd = 0; sel = 3'b111; wdata = 36'h5;
    tick(); idle_in();
    check_flags("R9");
  endtask

  task automatic t_empty_read();
    do_reset();
    push(36'h7_7777_0001);
    pop("R2");
    pop("R4");
    check_flags("R4");
    req = 1; rd = 1; en = 0;
    tick();
    chk(ack == 0, "R13", "ack read-empty", ack, 0);
    idle_in();
  endtask

  task automatic t_offsets();
    do_reset();
    wr_reg(3'b011, 36'hF_FFFF_FF05, 1); ae_m = 5;
    wr_reg(3'b001, 36'h0_0000_0014, 1);
    wr_reg(3'b000, 36'h0_0000_0030, 1);
    wr_reg(3'b110, 36'h0_0000_0020, 1);
    wr_reg(3'b100, 36'h0_0000_0021, 1);
    wr_reg(3'b011, 36'h0_0000_0002, 0);
    check_flags("R7");
    for (int i = 0; i < 6; i++) begin
      push(36'(i + 100));
      check_flags("R7");
      check_flags("R9");
    end
    // fields: 7:0=3, 16:9=10, 25:18=0x77, 34:27=0x55, gap bits set
    wr_reg(3'b101, (36'h1 << 35) | (36'h55 << 27) | (36'h1 << 26) | (36'h77 << 18)
                 | (36'h1 << 17) | (36'd10 << 9) | (36'h1 << 8) | 36'd3, 1);
    ae_m = 3; af_m = 10;
    check_flags("R8");
    for (int i = 0; i < 3; i++) begin
      pop("R2");
      check_flags("R8");
    end
    while (count_m < 247) begin
      push(36'(count_m) ^ 36'h3_C3C3_C3C3);
      if (count_m >= 244) check_flags("R6");
    end
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 0; i < 256; i++) begin
      push(36'(i) ^ 36'hA_5A5A_5A5A);
      check_flags("R5");
      check_flags("R6");
    end
    en = 1; req = 1; rd = 0; sel = 3'b111; wdata = 36'hD_EAD0_0BAD;
    tick();
    chk(ack == 0, "R13", "ack write-full", ack, 0);
    idle_in();
    check_flags("R3");
    do_rewind();
    check_flags("R10");
    for (int i = 0; i < 256; i++) begin
      pop("R3");
      if (i >= 120) check_flags("R5");
    end
  endtask

  task automatic t_rewind();
    do_reset();
    for (int i = 0; i < 5; i++) push(36'(i) * 36'h1_1111_1111);
    for (int i = 0; i < 5; i++) pop("R2");
    do_rewind();
    check_flags("R10");
    for (int i = 0; i < 5; i++) pop("R10");
    check_flags("R10");
    push(36'h9_8765_4321);
    pop("R10");
  endtask

  task automatic t_ack();
    do_reset();
    for (int i = 0; i < 100; i++) push(36'(i));
    en = 0; req = 1; rd = 0; sel = 3'b111;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(ack == 1, "R11", "ack steady write", ack, 1);
    end
    req = 0;
    tick();
    chk(ack == 0, "R11", "ack after drop", ack, 0);
    idle_in();
    while (count_m < 250) push(36'(count_m));
    repeat (3) tick();
    en = 0; req = 1; rd = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(ack == (i % 3 == 0), "R12", "ack paced", ack, i % 3 == 0);
    end
    rd = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(ack == 1, "R11", "ack steady read", ack, 1);
    end
    idle_in();
    check_flags("R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run too long act=%0d exp=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_empty_read();
    t_offsets();
    t_fill();
    t_rewind();
    t_ack();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule